// File: doc/BRIEF.md
# Strict Bit-Manipulation Shift-Immediate Decoder

This block decodes the register-immediate arithmetic major opcode of a 32-bit RISC-V core, covering the two function codes that carry shift and single-bit operations (funct3 001 and 101). It takes an instruction word with a valid strobe. It returns a one-hot select for nine operations (logical left shift, logical right shift, arithmetic right shift, rotate right, bit clear, bit set, bit invert, bit extract and byte reverse). It also returns the shift amount, the destination and source register indices, and an illegal flag.

The decoder compares every bit of the upper immediate field. This includes instruction bit 25, which is the sixth shift-amount bit and is reserved on a 32-bit machine. As a result, each operation has exactly one encoding that reaches it. Any near miss is flagged illegal and carries an all-zero select, so no execution unit is woken for it. A parameter chooses between a registered output stage, which is the default and adds one cycle, and a purely combinational path.

Top module: `bmi_imm_decoder`

## Requirements
- R1: A valid word whose opcode bits [6:0] differ from 7'b0010011, or whose funct3 bits [14:12] are neither 3'b001 nor 3'b101, gives an all-zero opSel and illegal low.
- R2: These exact (funct3, bits[31:25]) pairs select the given opSel bit: (001, 0000000) bit 0 left shift; (101, 0000000) bit 1 logical right shift; (101, 0100000) bit 2 arithmetic right shift; (101, 0110000) bit 3 rotate right; (001, 0100100) bit 4 bit clear; (001, 0010100) bit 5 bit set; (001, 0110100) bit 6 bit invert; (101, 0100100) bit 7 bit extract.
- R3: Byte reverse (opSel bit 8) is selected only for funct3 101 with bits[31:20] equal to 12'h698. Any other value of bits[24:20] under the (101, 0110100) pair is illegal.
- R4: A valid word with the matching opcode, funct3 001 or 101, and bit 25 set is always illegal with an all-zero opSel.
- R5: Any other bits[31:25] value under funct3 001 or 101 with the matching opcode is illegal with an all-zero opSel.
- R6: opSel never has more than one bit set, and it is all zero whenever illegal is high.
- R7: When outValid is high, shamt equals bits[24:20], rdIdx equals bits[11:7] and rs1Idx equals bits[19:15] of the accepted word.
- R8: With the registered stage, outValid, opSel and illegal appear on the first rising edge after the word is presented. An active-low reset clears outValid, opSel, illegal and the fields, and reset wins over a word presented in the same cycle.
- R9: A word presented with inValid low gives outValid low, an all-zero opSel and illegal low one cycle later, whatever its bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| outValid | output | 1 | Decode result is present |
| opSel | output | 9 | One-hot operation select |
| illegal | output | 1 | Reserved encoding in the claimed space |
| shamt | output | 5 | Shift amount or bit index |
| rdIdx | output | 5 | Destination register index |
| rs1Idx | output | 5 | Source register index |

## Verification
The main overlap is between accepting a legal operation and rejecting its near miss. Both paths are resolved from the same upper-immediate comparison in the same cycle. The bench drives each legal encoding back to back with its bit-25 variant, so a decoder that checks only six of the seven upper bits shows a select in the cycle where illegal must be set. The second overlap is reset arriving in the same cycle as a valid word. Here the bench checks that the output stays cleared, and that the word is decoded once reset is released.

// File: rtl/bmi_imm_pkg.sv
`timescale 1ns/1ps
package bmi_imm_pkg;
  localparam int ILEN    = 32;
  localparam int REG_W   = 5;
  localparam int NUM_OPS = 9;
  localparam int F7_W    = 7;
  localparam int F3_W    = 3;

  localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
  localparam logic [F3_W-1:0] F3_LEFT  = 3'b001;
  localparam logic [F3_W-1:0] F3_RIGHT = 3'b101;

  localparam int OP_SLL  = 0;
  localparam int OP_SRL  = 1;
  localparam int OP_SRA  = 2;
  localparam int OP_ROR  = 3;
  localparam int OP_BCLR = 4;
  localparam int OP_BSET = 5;
  localparam int OP_BINV = 6;
  localparam int OP_BEXT = 7;
  localparam int OP_REV  = 8;

  typedef struct packed {
    logic [F3_W-1:0]  f3;
    logic [F7_W-1:0]  f7;
    logic             fixLow;
    logic [REG_W-1:0] low;
  } pattern_t;

  typedef struct packed {
    logic               claim;
    logic [NUM_OPS-1:0] match;
  } dec_strobe_t;

  function automatic pattern_t opPattern(input int idx);
    pattern_t p;
    p = '0;
    case (idx)
      OP_SLL:  begin p.f3 = F3_LEFT;  p.f7 = 7'b0000000; end
      OP_SRL:  begin p.f3 = F3_RIGHT; p.f7 = 7'b0000000; end
      OP_SRA:  begin p.f3 = F3_RIGHT; p.f7 = 7'b0100000; end
      OP_ROR:  begin p.f3 = F3_RIGHT; p.f7 = 7'b0110000; end
      OP_BCLR: begin p.f3 = F3_LEFT;  p.f7 = 7'b0100100; end
      OP_BSET: begin p.f3 = F3_LEFT;  p.f7 = 7'b0010100; end
      OP_BINV: begin p.f3 = F3_LEFT;  p.f7 = 7'b0110100; end
      OP_BEXT: begin p.f3 = F3_RIGHT; p.f7 = 7'b0100100; end
      OP_REV:  begin p.f3 = F3_RIGHT; p.f7 = 7'b0110100;
                     p.fixLow = 1'b1; p.low = 5'b11000; end
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bmi_imm_ctrl.sv
`timescale 1ns/1ps
module bmi_imm_ctrl
  import bmi_imm_pkg::*;
(
  input  logic [6:0]       opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic [F7_W-1:0]  hiImm,
  input  logic [REG_W-1:0] lowImm,
  output dec_strobe_t      strobe
);
  logic               spaceHit;
  logic [NUM_OPS-1:0] matchVec;

  // The claimed space: the right opcode and one of the two shift function codes.
  assign spaceHit = (opcode == OPC_OP_IMM) &&
                    ((funct3 == F3_LEFT) || (funct3 == F3_RIGHT));

  // Each operation needs an exact match on all seven upper bits, so bit 25 is
  // covered. Byte reverse also needs an exact match on the low immediate bits.
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    localparam pattern_t PAT = opPattern(i);
    logic lowOk;
    if (PAT.fixLow) begin : g_fix
      assign lowOk = (lowImm == PAT.low);
    end else begin : g_free
      assign lowOk = 1'b1;
    end
    assign matchVec[i] = (funct3 == PAT.f3) && (hiImm == PAT.f7) && lowOk;
  end

  always_comb begin
    strobe.claim = spaceHit;
    strobe.match = spaceHit ? matchVec : '0;
  end
endmodule

// File: rtl/bmi_imm_dp.sv
`timescale 1ns/1ps
module bmi_imm_dp
  import bmi_imm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  dec_strobe_t        strobe,
  input  logic [REG_W-1:0]   shamtIn,
  input  logic [REG_W-1:0]   rdIn,
  input  logic [REG_W-1:0]   rs1In,
  output logic               outValid,
  output logic [NUM_OPS-1:0] opSel,
  output logic               illegal,
  output logic [REG_W-1:0]   shamt,
  output logic [REG_W-1:0]   rdIdx,
  output logic [REG_W-1:0]   rs1Idx
);
  logic [NUM_OPS-1:0] opNext;
  logic               illNext;

  // A rejected word never drives a select, so nothing downstream toggles.
  always_comb begin
    opNext  = (inValid && strobe.claim) ? strobe.match : '0;
    illNext = inValid && strobe.claim && (strobe.match == '0);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid <= 1'b0;
        opSel    <= '0;
        illegal  <= 1'b0;
        shamt    <= '0;
        rdIdx    <= '0;
        rs1Idx   <= '0;
      end else begin
        outValid <= inValid;
        opSel    <= opNext;
        illegal  <= illNext;
        if (inValid) begin
          shamt  <= shamtIn;
          rdIdx  <= rdIn;
          rs1Idx <= rs1In;
        end
      end
    end
  end else begin : g_comb
    assign outValid = inValid;
    assign opSel    = opNext;
    assign illegal  = illNext;
    assign shamt    = shamtIn;
    assign rdIdx    = rdIn;
    assign rs1Idx   = rs1In;
  end
endmodule

// File: rtl/bmi_imm_decoder.sv
`timescale 1ns/1ps
module bmi_imm_decoder
  import bmi_imm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ILEN-1:0]    instr,
  output logic               outValid,
  output logic [NUM_OPS-1:0] opSel,
  output logic               illegal,
  output logic [REG_W-1:0]   shamt,
  output logic [REG_W-1:0]   rdIdx,
  output logic [REG_W-1:0]   rs1Idx
);
  dec_strobe_t strobe;

  bmi_imm_ctrl uCtrl (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .hiImm  (instr[31:25]),
    .lowImm (instr[24:20]),
    .strobe (strobe)
  );

  bmi_imm_dp #(.REG_OUT(REG_OUT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .shamtIn  (instr[24:20]),
    .rdIn     (instr[11:7]),
    .rs1In    (instr[19:15]),
    .outValid (outValid),
    .opSel    (opSel),
    .illegal  (illegal),
    .shamt    (shamt),
    .rdIdx    (rdIdx),
    .rs1Idx   (rs1Idx)
  );
endmodule

// File: rtl/bmi_imm_chk.sv
`timescale 1ns/1ps
module bmi_imm_chk
  import bmi_imm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [6:0]         opcodeIn,
  input logic [F3_W-1:0]    funct3In,
  input logic               bit25In,
  input logic [REG_W-1:0]   shamtIn,
  input logic               outValid,
  input logic [NUM_OPS-1:0] opSel,
  input logic               illegal,
  input logic [REG_W-1:0]   shamt
);
  logic reservedHit;
  assign reservedHit = inValid && (opcodeIn == OPC_OP_IMM) && bit25In &&
                       ((funct3In == F3_LEFT) || (funct3In == F3_RIGHT));

  // R6
  one_hot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opSel));

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (opSel == '0) && outValid);

  if (REG_OUT) begin : g_seq
    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid && !illegal && (opSel == '0));

    // R4
    reserved_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
      reservedHit |=> illegal && (opSel == '0));

    // R7
    shamt_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> (shamt == $past(shamtIn)));
  end else begin : g_cmb
    // R4
    reserved_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
      reservedHit |-> illegal && (opSel == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |-> !outValid && !illegal);
  end
endmodule

bind bmi_imm_decoder bmi_imm_chk #(.REG_OUT(REG_OUT)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opcodeIn (instr[6:0]),
  .funct3In (instr[14:12]),
  .bit25In  (instr[25]),
  .shamtIn  (instr[24:20]),
  .outValid (outValid),
  .opSel    (opSel),
  .illegal  (illegal),
  .shamt    (shamt)
);

// File: tb/tb_bmi_imm_decoder.sv
`timescale 1ns/1ps
module tb_bmi_imm_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic        outValid, illegal;
  logic [8:0]  opSel;
  logic [4:0]  shamt, rdIdx, rs1Idx;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bmi_imm_decoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .outValid(outValid), .opSel(opSel), .illegal(illegal),
    .shamt(shamt), .rdIdx(rdIdx), .rs1Idx(rs1Idx)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] sh,
                                     input logic [4:0] rs, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, sh, rs, f3, rd, opc};
  endfunction

  // entry = {word, expected select index (15 = none), expected illegal}
  function automatic logic [36:0] ent(input logic [31:0] w, input logic [3:0] idx,
                                      input logic ill);
    return {w, idx, ill};
  endfunction

  localparam int NV = 22;
  localparam logic [6:0] OI = 7'b0010011;
  localparam logic [36:0] VEC [NV] = '{
    ent(mk(7'b0000000, 5'd3,  5'd1,  3'b001, 5'd2,  OI), 4'd0,  1'b0), // R2 sll
    ent(mk(7'b0000000, 5'd31, 5'd4,  3'b101, 5'd5,  OI), 4'd1,  1'b0), // R2 srl
    ent(mk(7'b0100000, 5'd9,  5'd6,  3'b101, 5'd7,  OI), 4'd2,  1'b0), // R2 sra
    ent(mk(7'b0110000, 5'd7,  5'd8,  3'b101, 5'd9,  OI), 4'd3,  1'b0), // R2 ror
    ent(mk(7'b0110001, 5'd7,  5'd8,  3'b101, 5'd9,  OI), 4'd15, 1'b1), // R4 ror b25
    ent(mk(7'b0100100, 5'd12, 5'd10, 3'b001, 5'd11, OI), 4'd4,  1'b0), // R2 bclr
    ent(mk(7'b0100101, 5'd12, 5'd10, 3'b001, 5'd11, OI), 4'd15, 1'b1), // R4 bclr b25
    ent(mk(7'b0010100, 5'd0,  5'd13, 3'b001, 5'd14, OI), 4'd5,  1'b0), // R2 bset
    ent(mk(7'b0010101, 5'd0,  5'd13, 3'b001, 5'd14, OI), 4'd15, 1'b1), // R4 bset b25
    ent(mk(7'b0110100, 5'd17, 5'd15, 3'b001, 5'd16, OI), 4'd6,  1'b0), // R2 binv
    ent(mk(7'b0110101, 5'd17, 5'd15, 3'b001, 5'd16, OI), 4'd15, 1'b1), // R4 binv b25
    ent(mk(7'b0100100, 5'd30, 5'd18, 3'b101, 5'd19, OI), 4'd7,  1'b0), // R2 bext
    ent(mk(7'b0100101, 5'd30, 5'd18, 3'b101, 5'd19, OI), 4'd15, 1'b1), // R4 bext b25
    ent(mk(7'b0110100, 5'd24, 5'd20, 3'b101, 5'd21, OI), 4'd8,  1'b0), // R3 rev
    ent(mk(7'b0110100, 5'd23, 5'd20, 3'b101, 5'd21, OI), 4'd15, 1'b1), // R3 rev low
    ent(mk(7'b0110101, 5'd24, 5'd20, 3'b101, 5'd21, OI), 4'd15, 1'b1), // R4 rev b25
    ent(mk(7'b0000001, 5'd3,  5'd22, 3'b001, 5'd23, OI), 4'd15, 1'b1), // R4 sll b25
    ent(mk(7'b0100001, 5'd3,  5'd24, 3'b101, 5'd25, OI), 4'd15, 1'b1), // R4 sra b25
    ent(mk(7'b0110000, 5'd5,  5'd26, 3'b001, 5'd27, OI), 4'd15, 1'b1), // R5
    ent(mk(7'b0010100, 5'd5,  5'd28, 3'b101, 5'd29, OI), 4'd15, 1'b1), // R5
    ent(mk(7'b0110001, 5'd5,  5'd30, 3'b000, 5'd31, OI), 4'd15, 1'b0), // R1 f3
    ent(mk(7'b0110000, 5'd5,  5'd3,  3'b101, 5'd1,  7'b0110011), 4'd15, 1'b0) // R1 opc
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w);
    @(negedge clk);
    inValid = v;
    instr = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check(!outValid && !illegal && opSel == '0 && shamt == '0 && rdIdx == '0 && rs1Idx == '0,
          "R8 reset", {outValid, illegal, opSel}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      logic [8:0]  eOp;
      w = VEC[i][36:5];
      eOp = (VEC[i][4:1] == 4'd15) ? 9'd0 : (9'd1 << VEC[i][4:1]);
      drive(1'b1, w);
      // R2 R3 R4 R5 R1: select and illegal flag per vector
      check(opSel == eOp, $sformatf("R2 opSel vec %0d", i), opSel, eOp);
      check(illegal == VEC[i][0], $sformatf("R4 illegal vec %0d", i), illegal, VEC[i][0]);
      // R6
      check($onehot0(opSel) && !(illegal && opSel != '0), "R6 onehot", opSel, eOp);
      // R7 and R8
      check(outValid && shamt == w[24:20] && rdIdx == w[11:7] && rs1Idx == w[19:15],
            $sformatf("R7 fields vec %0d", i), {outValid, shamt, rdIdx, rs1Idx},
            {1'b1, w[24:20], w[11:7], w[19:15]});
    end

    // R9: a reserved word with inValid low stays silent
    drive(1'b0, mk(7'b0110001, 5'd7, 5'd8, 3'b101, 5'd9, OI));
    check(!outValid && !illegal && opSel == '0, "R9 idle", {outValid, illegal, opSel}, 32'h0);

    // R8: reset in the same cycle as a valid rotate
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b1;
    instr = mk(7'b0110000, 5'd4, 5'd2, 3'b101, 5'd3, OI);
    @(posedge clk);
    #1;
    check(!outValid && opSel == '0 && !illegal, "R8 reset wins", {outValid, opSel}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(outValid && opSel == 9'd8 && !illegal, "R8 after release", opSel, 32'd8);

    // R8: combinational changes before the edge are not visible yet
    @(negedge clk);
    instr = mk(7'b0110001, 5'd4, 5'd2, 3'b101, 5'd3, OI);
    #1;
    check(opSel == 9'd8 && !illegal, "R8 latency hold", opSel, 32'd8);
    @(posedge clk);
    #1;
    check(illegal && opSel == '0, "R8 latency update", {illegal, opSel}, 32'h200);

    drive(1'b0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule